// File: doc/BRIEF.md
# Transmit Packet Byte FIFO with Fill Status

This block buffers outgoing packet bytes between a register-side writer and a packet processor that drains them. Every entry holds one data byte plus a small status tag that travels with it, so packet boundaries or other per-byte markers come out of the FIFO aligned with their data. All transfers move one byte per strobe, and both sides share a single clock.

The block keeps a fill count and decodes three status flags from it: empty, full, and a storage-available flag that compares the free space against a threshold supplied on a configuration input. Illegal accesses are recorded in two sticky error bits. A write that arrives while the FIFO is full is dropped and sets the overflow bit. A read that arrives while the FIFO is empty sets the underflow bit, leaves the read pointer where it is, and keeps the read outputs unchanged. Both bits stay set until a clear strobe.

Top module: `txpkt_fifo`

## Requirements
- R1: After reset, level is 0, empty is 1, full is 0, space_ok follows R8, overflow and underflow are 0, and rd_data and rd_tag are 0.
- R2: Bytes and tags are read out in the order they were accepted. The entry for an accepted read appears on rd_data and rd_tag just after the clock edge that samples rd_en, and stays there until the next accepted read.
- R3: A write sampled while full is 1 is discarded. The level does not rise, the byte never appears at the read side, and overflow is 1 after that edge.
- R4: A read sampled while empty is 1 sets underflow after that edge. rd_data and rd_tag keep their previous values, and the next byte written is the next byte read.
- R5: level counts the held entries from 0 to 256. An accepted write raises it by one, an accepted read lowers it by one, and a write and a read accepted in the same cycle leave it unchanged.
- R6: empty is 1 exactly when level is 0.
- R7: full is 1 exactly when level is 256.
- R8: space_ok is 1 exactly when 256 minus level is at least space_thresh. space_thresh is a 9-bit unsigned count.
- R9: overflow and underflow stay at 1 until err_clear is sampled high. If a new error event and err_clear occur in the same cycle, the bit stays set.
- R10: The FIFO holds exactly 256 entries. After 256 writes from empty, all 256 come back in order with their tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Byte to store |
| wr_tag | input | 2 | Status tag stored with the byte |
| rd_en | input | 1 | Read strobe from the packet processor |
| rd_data | output | 8 | Last byte read |
| rd_tag | output | 2 | Tag of the last byte read |
| space_thresh | input | 9 | Free-space threshold for space_ok |
| err_clear | input | 1 | Clears both sticky error bits |
| level | output | 9 | Number of held entries |
| empty | output | 1 | No entries held |
| full | output | 1 | No free entry |
| space_ok | output | 1 | Free space is at least space_thresh |
| overflow | output | 1 | Sticky: write attempted while full |
| underflow | output | 1 | Sticky: read attempted while empty |

## Verification
The read outputs, level and the sticky bits are all registered, so each result is due at the first rising edge after the stimulus is sampled. empty, full and space_ok are decoded without a register from level and space_thresh, so they move in the same cycle as level. The driver applies stimulus at the falling edge. The monitor compares the read outputs 1 ns after the next rising edge against the entry popped from the scoreboard queue, or against the held value when the FIFO was empty. The driver checks level, the flags and the error bits 2 ns after that same edge against its own count model.

// File: rtl/txfifo_pkg.sv
package txfifo_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned TAG_W  = 2;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [BYTE_W-1:0] data;
  } fifo_entry_t;

  // level after one cycle of accepted write/read
  function automatic int unsigned next_level(int unsigned lvl, logic inc, logic dec);
    int unsigned n;
    n = lvl;
    if (inc && !dec) n = lvl + 1;
    else if (dec && !inc) n = lvl - 1;
    return n;
  endfunction

  // free entries given the fill level
  function automatic int unsigned free_space(int unsigned lvl, int unsigned depth);
    return depth - lvl;
  endfunction

  function automatic logic meets_threshold(int unsigned lvl, int unsigned depth,
                                           int unsigned thr);
    return free_space(lvl, depth) >= thr;
  endfunction

  // pointer advance with wrap for any depth
  function automatic int unsigned ptr_step(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/txfifo_ctrl.sv
module txfifo_ctrl #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [LW-1:0] level,
  output logic          wr_accept,
  output logic          rd_accept,
  output logic          wr_drop,
  output logic          rd_miss
);
  import txfifo_pkg::*;

  logic is_full;
  logic is_empty;

  assign is_full   = (level == LW'(DEPTH));
  assign is_empty  = (level == '0);
  assign wr_accept = wr_en && !is_full;
  assign rd_accept = rd_en && !is_empty;
  assign wr_drop   = wr_en && is_full;
  assign rd_miss   = rd_en && is_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_accept) wr_ptr <= AW'(ptr_step(32'(wr_ptr), DEPTH));
      if (rd_accept) rd_ptr <= AW'(ptr_step(32'(rd_ptr), DEPTH));
      level <= LW'(next_level(32'(level), wr_accept, rd_accept));
    end
  end

endmodule

// File: rtl/txfifo_store.sv
module txfifo_store #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  txfifo_pkg::fifo_entry_t  wentry,
  input  logic                     re,
  input  logic [AW-1:0]            raddr,
  output txfifo_pkg::fifo_entry_t  rentry
);
  import txfifo_pkg::*;

  fifo_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wentry;
  end

  // output register holds on a missed read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rentry <= '0;
    else if (re) rentry <= mem[raddr];
  end

endmodule

// File: rtl/txfifo_status.sv
module txfifo_status #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned LW = $clog2(DEPTH + 1),
  localparam int unsigned NERR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LW-1:0]   level,
  input  logic [LW-1:0]   thresh,
  input  logic [NERR-1:0] err_event,
  input  logic            err_clear,
  output logic            empty,
  output logic            full,
  output logic            space_ok,
  output logic [NERR-1:0] err_flag
);
  import txfifo_pkg::*;

  assign empty    = (level == '0);
  assign full     = (level == LW'(DEPTH));
  assign space_ok = meets_threshold(32'(level), DEPTH, 32'(thresh));

  // one sticky bit per error source; a new event outranks the clear
  for (genvar i = 0; i < NERR; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_flag[i] <= 1'b0;
      else if (err_event[i]) err_flag[i] <= 1'b1;
      else if (err_clear) err_flag[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/txpkt_fifo.sv
module txpkt_fifo #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1),
  localparam int unsigned DW = txfifo_pkg::BYTE_W,
  localparam int unsigned TW = txfifo_pkg::TAG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [TW-1:0] wr_tag,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [TW-1:0] rd_tag,
  input  logic [LW-1:0] space_thresh,
  input  logic          err_clear,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          space_ok,
  output logic          overflow,
  output logic          underflow
);
  import txfifo_pkg::*;

  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          wr_accept;
  logic          rd_accept;
  logic          wr_drop;
  logic          rd_miss;
  fifo_entry_t   in_entry;
  fifo_entry_t   out_entry;
  logic [1:0]    err_flag;

  assign in_entry.data = wr_data;
  assign in_entry.tag  = wr_tag;

  txfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .level     (level),
    .wr_accept (wr_accept),
    .rd_accept (rd_accept),
    .wr_drop   (wr_drop),
    .rd_miss   (rd_miss)
  );

  txfifo_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_accept),
    .waddr  (wr_ptr),
    .wentry (in_entry),
    .re     (rd_accept),
    .raddr  (rd_ptr),
    .rentry (out_entry)
  );

  txfifo_status #(.DEPTH(DEPTH)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (level),
    .thresh    (space_thresh),
    .err_event ({rd_miss, wr_drop}),
    .err_clear (err_clear),
    .empty     (empty),
    .full      (full),
    .space_ok  (space_ok),
    .err_flag  (err_flag)
  );

  assign rd_data   = out_entry.data;
  assign rd_tag    = out_entry.tag;
  assign overflow  = err_flag[0];
  assign underflow = err_flag[1];

endmodule

// File: rtl/txpkt_fifo_checker.sv
module txpkt_fifo_checker #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          err_clear,
  input logic [7:0]    rd_data,
  input logic [1:0]    rd_tag,
  input logic [LW-1:0] level,
  input logic          empty,
  input logic          full,
  input logic          overflow,
  input logic          underflow,
  input logic          wr_drop,
  input logic          rd_miss
);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> overflow);

  assert_drop_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> $stable(level));

  assert_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> (underflow && $stable(rd_data) && $stable(rd_tag)));

  assert_level_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && !rd_en) |=> (level == $past(level) + 1'b1));

  assert_level_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty && !wr_en) |=> (level == $past(level) - 1'b1));

  assert_level_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  assert_flags_exclusive_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({empty, full}));

  assert_sticky_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !err_clear) |=> overflow);

  assert_sticky_unf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !err_clear) |=> underflow);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear && !wr_drop && !rd_miss) |=> (!overflow && !underflow));

endmodule

bind txpkt_fifo txpkt_fifo_checker #(.DEPTH(DEPTH)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .err_clear (err_clear),
  .rd_data   (rd_data),
  .rd_tag    (rd_tag),
  .level     (level),
  .empty     (empty),
  .full      (full),
  .overflow  (overflow),
  .underflow (underflow),
  .wr_drop   (wr_drop),
  .rd_miss   (rd_miss)
);

// File: tb/txpkt_fifo_test.sv
module txpkt_fifo_test;

  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] wr_tag = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] rd_tag;
  logic [8:0] space_thresh = '0;
  logic       err_clear = 1'b0;
  logic [8:0] level;
  logic       empty, full, space_ok, overflow, underflow;

  txpkt_fifo uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
    .rd_en(rd_en), .rd_data(rd_data), .rd_tag(rd_tag), .space_thresh(space_thresh),
    .err_clear(err_clear), .level(level), .empty(empty), .full(full),
    .space_ok(space_ok), .overflow(overflow), .underflow(underflow)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // scoreboard state
  logic [9:0] exp_q[$];
  logic [9:0] last_out = '0;
  logic [9:0] exp_item = '0;
  bit         exp_valid = 0;
  string      exp_req = "R2";
  int         m_lvl = 0;
  bit         m_ovf = 0;
  bit         m_unf = 0;
  bit         done = 0;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: read outputs due 1 ns after the edge that sampled rd_en
  always @(posedge clk) begin
    #1;
    if (exp_valid) begin
      check(exp_req, "rd_data", int'(rd_data), int'(exp_item[7:0]));
      check(exp_req, "rd_tag", int'(rd_tag), int'(exp_item[9:8]));
      exp_valid = 0;
    end
  end

  task automatic check_status();
    check("R5", "level", int'(level), m_lvl);
    check("R6", "empty", int'(empty), int'(m_lvl == 0));
    check("R7", "full", int'(full), int'(m_lvl == DEPTH));
    check("R8", "space_ok", int'(space_ok), int'((DEPTH - m_lvl) >= int'(space_thresh)));
    check("R3 R9", "overflow", int'(overflow), int'(m_ovf));
    check("R4 R9", "underflow", int'(underflow), int'(m_unf));
  endtask

  // driver: one cycle of stimulus, model update, status check
  task automatic step(bit wr, logic [7:0] d, logic [1:0] t, bit rd, bit clr);
    bit rd_ok, wr_ok;
    @(negedge clk);
    wr_en = wr; wr_data = d; wr_tag = t; rd_en = rd; err_clear = clr;
    rd_ok = rd && (m_lvl > 0);
    wr_ok = wr && (m_lvl < DEPTH);
    if (rd) begin
      if (rd_ok) begin
        last_out = exp_q.pop_front();
        exp_req = "R2";
      end else begin
        exp_req = "R4";
      end
      exp_item = last_out;
      exp_valid = 1;
    end
    if (wr_ok) exp_q.push_back({t, d});
    m_lvl = m_lvl + int'(wr_ok) - int'(rd_ok);
    if (wr && !wr_ok) m_ovf = 1; else if (clr) m_ovf = 0;
    if (rd && !rd_ok) m_unf = 1; else if (clr) m_unf = 0;
    @(posedge clk);
    #2;
    check_status();
  endtask

  task automatic idle();
    step(0, 8'h00, 2'b00, 0, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    space_thresh = 9'd255;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check("R1", "rd_data", int'(rd_data), 0);
    check("R1", "rd_tag", int'(rd_tag), 0);
    check_status();
    @(negedge clk); rst_n = 1'b1;

    // R2, R5, R8: small burst, thresholds around 255 free
    step(1, 8'hA1, 2'd1, 0, 0);
    step(1, 8'hB2, 2'd2, 0, 0);
    step(1, 8'hC3, 2'd3, 0, 0);
    step(0, 8'h00, 2'd0, 1, 0);
    // R5: simultaneous read and write keep the level
    step(1, 8'hD4, 2'd0, 1, 0);
    step(1, 8'hE5, 2'd1, 1, 0);
    step(0, 8'h00, 2'd0, 1, 0);
    step(0, 8'h00, 2'd0, 1, 0);
    // R4: read while empty holds the output and sets underflow
    step(0, 8'h00, 2'd0, 1, 0);
    idle();
    // R4: read pointer did not move; next write is next read
    step(1, 8'h5A, 2'd2, 0, 0);
    step(0, 8'h00, 2'd0, 1, 0);
    // R9: a clear in the same cycle as a new miss leaves the bit set
    step(0, 8'h00, 2'd0, 1, 1);
    step(0, 8'h00, 2'd0, 0, 1);
    idle();

    // R10, R7, R8: fill to exactly DEPTH with threshold 1
    space_thresh = 9'd1;
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i * 7 + 3), 2'(i), 0, 0);
    // R3: write while full is dropped
    step(1, 8'hEE, 2'd3, 0, 0);
    idle();
    // R3: full with read and write together, write dropped
    step(1, 8'h77, 2'd1, 1, 0);
    step(1, 8'h66, 2'd2, 0, 0);
    space_thresh = 9'd0;
    idle();
    // R10, R2: drain everything in order
    for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 2'd0, 1, 0);
    step(0, 8'h00, 2'd0, 1, 1);
    space_thresh = 9'd256;
    step(0, 8'h00, 2'd0, 0, 1);
    step(1, 8'h11, 2'd1, 0, 0);
    idle();
    done = 1;
    summary();
  end

endmodule